// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out where an instruction's argument lives and where the next instruction starts, for a small 8-bit processor with a 16-bit address space. The decoder hands it an addressing-mode code with a one-cycle start strobe, along with the address of the opcode, the index register and the branch-condition result. The unit then reads the instruction bytes that follow the opcode, one per cycle, over a plain byte-read port. The memory returns each byte in the cycle after the read.

When the result is ready, the unit raises a one-cycle done strobe. With it come the effective address, the immediate operand (for immediate mode), the instruction length and the next program counter. Five modes are handled: immediate, page-zero direct, full-width extended, branch-relative and zero-offset indexed. Any other mode code gets a flagged fallback.

Top module: `ea_gen_unit`

## Requirements
- R1: Reset is synchronous and active-high. In the cycle after a reset edge, `done_o`, `busy_o` and `mem_rd_o` are low, and an operation in flight is abandoned with no done pulse.
- R2: A start is taken only while idle; a start while `busy_o` is high, including on the done cycle, is ignored. Reads go to opcode+1 and then opcode+2, one per cycle. The done pulse lasts one cycle and comes 1 cycle after start for 0-byte modes, 3 cycles for 1-byte modes and 4 cycles for extended mode.
- R3: Mode code 0 (immediate): `ea_o` = opcode+1, `operand_o` = the fetched byte, length 2, next PC = opcode+2. In every other mode `operand_o` is zero.
- R4: Mode code 1 (direct): `ea_o` = {8'h00, fetched byte}, length 2, next PC = opcode+2.
- R5: Mode code 2 (extended): the first fetched byte is the address high byte and the second is the low byte. Length 3, next PC = opcode+3.
- R6: Mode code 3 (relative) with `taken_i` high: the target is opcode+2 plus the sign-extended fetched byte, covering −128..+127. `ea_o` and next PC both equal the target, and the length is 2.
- R7: Mode code 3 with `taken_i` low: next PC = opcode+2, and `ea_o` still shows the target.
- R8: Mode code 4 (indexed, no offset): `ea_o` = {8'h00, index}, length 1, next PC = opcode+1, and no memory read is made.
- R9: Mode codes 5..7: `illegal_o` is high with done, `ea_o` = 0, length 1, next PC = opcode+1, and no memory read is made.
- R10: All address arithmetic (fetch addresses, next PC, branch target) wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an address computation (taken only while idle) |
| mode_i | input | 3 | Addressing-mode code |
| opc_addr_i | input | 16 | Address of the opcode byte |
| index_i | input | 8 | Index register value |
| taken_i | input | 1 | Branch condition is true |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Byte read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Unit is not idle |
| done_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | Unknown mode code, valid with done |
| ea_o | output | 16 | Effective address, valid with done |
| operand_o | output | 8 | Immediate operand, valid with done |
| len_o | output | 2 | Instruction length in bytes, valid with done |
| next_pc_o | output | 16 | Next program counter, valid with done |

## Verification
Two events can fall in the same cycle: a new start request and an operation still running, including its done cycle. The bench provokes this by holding `start_i` high through a whole extended-mode access, with the mode input switched to indexed after the first edge. It expects exactly one done pulse, carrying the extended result, the 4-cycle latency and two reads. A second case pulses reset halfway through a fetch and expects no done pulse afterwards. The scoreboard treats any done pulse it did not expect as a failure.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] AM_IMM = 3'd0;
   localparam logic [MODE_W-1:0] AM_DIR = 3'd1;
   localparam logic [MODE_W-1:0] AM_EXT = 3'd2;
   localparam logic [MODE_W-1:0] AM_REL = 3'd3;
   localparam logic [MODE_W-1:0] AM_IDX = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH1,
      ST_FETCH2,
      ST_TAIL,
      ST_DONE
   } seq_st_e;

   // number of bytes that follow the opcode for a given mode
   function automatic logic [1:0] trail_bytes(logic [MODE_W-1:0] m);
      case (m)
         AM_IMM, AM_DIR, AM_REL: trail_bytes = 2'd1;
         AM_EXT:                 trail_bytes = 2'd2;
         default:                trail_bytes = 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/ea_seq.sv
module ea_seq
   import ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] opc_i,
   input  logic [DATA_W-1:0] index_i,
   input  logic              taken_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [MODE_W-1:0] mode_q,
   output logic [ADDR_W-1:0] opc_q,
   output logic [DATA_W-1:0] idx_q,
   output logic              taken_q,
   output logic [DATA_W-1:0] byte1_q,
   output logic [DATA_W-1:0] byte2_q
);
   seq_st_e st_q, st_d;
   logic    two_bytes;

   assign two_bytes = (trail_bytes(mode_q) == 2'd2);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (start_i) st_d = (trail_bytes(mode_i) == 2'd0) ? ST_DONE : ST_FETCH1;
         ST_FETCH1: st_d = ST_FETCH2;
         ST_FETCH2: st_d = two_bytes ? ST_TAIL : ST_DONE;
         ST_TAIL:   st_d = ST_DONE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         mode_q  <= '0;
         opc_q   <= '0;
         idx_q   <= '0;
         taken_q <= 1'b0;
         byte1_q <= '0;
         byte2_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start_i) begin
            mode_q  <= mode_i;
            opc_q   <= opc_i;
            idx_q   <= index_i;
            taken_q <= taken_i;
            byte1_q <= '0;
            byte2_q <= '0;
         end
         if (st_q == ST_FETCH2) byte1_q <= mem_data_i;
         if (st_q == ST_TAIL)   byte2_q <= mem_data_i;
      end
   end

   assign mem_rd_o   = (st_q == ST_FETCH1) || (st_q == ST_FETCH2 && two_bytes);
   assign mem_addr_o = (st_q == ST_FETCH2) ? opc_q + ADDR_W'(2) : opc_q + ADDR_W'(1);
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] opc_i,
   input  logic [DATA_W-1:0] idx_i,
   input  logic              taken_i,
   input  logic [DATA_W-1:0] b1_i,
   input  logic [DATA_W-1:0] b2_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [1:0]        len_o,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              illegal_o
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] page0_b1, page0_idx, rel_off, ext_addr, seq_pc, tgt;

   assign page0_b1  = {{HI_W{1'b0}}, b1_i};
   assign page0_idx = {{HI_W{1'b0}}, idx_i};
   assign rel_off   = {{HI_W{b1_i[DATA_W-1]}}, b1_i};

   generate
      if (ADDR_W == 2*DATA_W) begin : g_ext_exact
         assign ext_addr = {b1_i, b2_i};
      end else begin : g_ext_pad
         assign ext_addr = {{(ADDR_W-2*DATA_W){1'b0}}, b1_i, b2_i};
      end
   endgenerate

   always_comb begin
      len_o = 2'd1;
      case (mode_i)
         AM_IMM, AM_DIR, AM_REL: len_o = 2'd2;
         AM_EXT:                 len_o = 2'd3;
         default:                len_o = 2'd1;
      endcase
   end

   assign seq_pc = opc_i + {{(ADDR_W-2){1'b0}}, len_o};
   assign tgt    = seq_pc + rel_off;

   always_comb begin
      ea_o      = '0;
      operand_o = '0;
      next_pc_o = seq_pc;
      illegal_o = 1'b0;
      case (mode_i)
         AM_IMM: begin
            ea_o      = opc_i + ADDR_W'(1);
            operand_o = b1_i;
         end
         AM_DIR: ea_o = page0_b1;
         AM_EXT: ea_o = ext_addr;
         AM_REL: begin
            ea_o = tgt;
            if (taken_i) next_pc_o = tgt;
         end
         AM_IDX: ea_o = page0_idx;
         default: illegal_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
   import ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] opc_addr_i,
   input  logic [DATA_W-1:0] index_i,
   input  logic              taken_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              illegal_o,
   output logic [ADDR_W-1:0] ea_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [1:0]        len_o,
   output logic [ADDR_W-1:0] next_pc_o
);
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("ea_gen_unit: DATA_W must be at least 2");
      end
      if (ADDR_W < 2*DATA_W) begin : g_bad_addr
         $error("ea_gen_unit: ADDR_W must hold two data bytes");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [ADDR_W-1:0] opc_q;
   logic [DATA_W-1:0] idx_q, byte1_q, byte2_q;
   logic              taken_q, bad_mode;

   ea_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
      .opc_i(opc_addr_i), .index_i(index_i), .taken_i(taken_i),
      .mem_data_i(mem_data_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
      .busy_o(busy_o), .done_o(done_o), .mode_q(mode_q), .opc_q(opc_q),
      .idx_q(idx_q), .taken_q(taken_q), .byte1_q(byte1_q), .byte2_q(byte2_q)
   );

   ea_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
      .mode_i(mode_q), .opc_i(opc_q), .idx_i(idx_q), .taken_i(taken_q),
      .b1_i(byte1_q), .b2_i(byte2_q), .ea_o(ea_o), .operand_o(operand_o),
      .len_o(len_o), .next_pc_o(next_pc_o), .illegal_o(bad_mode)
   );

   assign illegal_o = done_o && bad_mode;

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done_o && !busy_o && !mem_rd_o)); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R2
   AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (rst) mem_rd_o |-> (busy_o && !done_o)); // R2
   AST_IMM_RESULT: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_IMM) |-> (ea_o == opc_q + ADDR_W'(1) && operand_o == byte1_q && len_o == 2'd2)); // R3
   AST_DIR_PAGE0: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_DIR) |-> (ea_o[ADDR_W-1:DATA_W] == '0 && ea_o[DATA_W-1:0] == byte1_q)); // R4
   AST_EXT_LEN: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_EXT) |-> (len_o == 2'd3 && next_pc_o == opc_q + ADDR_W'(3))); // R5
   AST_REL_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_REL && taken_q) |-> (next_pc_o == ea_o)); // R6
   AST_REL_SKIP: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_REL && !taken_q) |-> (next_pc_o == opc_q + ADDR_W'(2))); // R7
   AST_IDX_PAGE0: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == AM_IDX) |-> (ea_o[ADDR_W-1:DATA_W] == '0 && len_o == 2'd1)); // R8
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> (done_o && ea_o == '0 && len_o == 2'd1)); // R9
endmodule

// File: tb/tb_ea_gen_unit.sv
`timescale 1ns/1ps
module tb_ea_gen_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [15:0] opc_addr_i = '0;
   logic [7:0]  index_i = '0;
   logic        taken_i = 1'b0;
   logic        mem_rd_o, busy_o, done_o, illegal_o;
   logic [15:0] mem_addr_o, ea_o, next_pc_o;
   logic [7:0]  mem_data_i = '0;
   logic [7:0]  operand_o;
   logic [1:0]  len_o;

   always #2.5 clk = ~clk;

   ea_gen_unit dut (
      .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
      .opc_addr_i(opc_addr_i), .index_i(index_i), .taken_i(taken_i),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
      .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .ea_o(ea_o),
      .operand_o(operand_o), .len_o(len_o), .next_pc_o(next_pc_o)
   );

   typedef struct {
      string       req;
      logic [15:0] ea;
      logic [7:0]  opd;
      logic [1:0]  len;
      logic [15:0] npc;
      logic        ill;
      int          lat;
      int          reads;
   } exp_t;

   exp_t        sb[$];
   int          n_run = 0, n_fail = 0;
   int          cyc = 0, rd_cnt = 0, t_start = 0, rd_start = 0;
   logic [15:0] mem_base = '0;
   logic [7:0]  mem_b1 = '0, mem_b2 = '0;

   // memory model: data appears the cycle after the read request
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd_o) begin
         rd_cnt <= rd_cnt + 1;
         if (mem_addr_o == 16'(mem_base + 16'd1))      mem_data_i <= mem_b1;
         else if (mem_addr_o == 16'(mem_base + 16'd2)) mem_data_i <= mem_b2;
         else                                          mem_data_i <= 8'hEE;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && done_o) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(ea_o == e.ea, e.req, "ea", ea_o, e.ea);
            check(operand_o == e.opd, e.req, "operand", operand_o, e.opd);
            check(len_o == e.len, e.req, "len", len_o, e.len);
            check(next_pc_o == e.npc, e.req, "next_pc", next_pc_o, e.npc);
            check(illegal_o == e.ill, e.req, "illegal", illegal_o, e.ill);
            check((cyc - t_start) == e.lat, "R2", "latency", cyc - t_start, e.lat);
            check((rd_cnt - rd_start) == e.reads, e.req, "reads", rd_cnt - rd_start, e.reads);
         end
      end
   end

   function automatic exp_t model(input string req, input logic [2:0] m, input logic [15:0] opc,
                                  input logic [7:0] idx, input logic tk,
                                  input logic [7:0] b1, input logic [7:0] b2);
      exp_t e;
      logic [15:0] tgt;
      e.req = req; e.opd = 8'h00; e.ill = 1'b0;
      tgt = 16'(opc + 16'd2 + {{8{b1[7]}}, b1});
      case (m)
         3'd0: begin e.ea = 16'(opc + 16'd1); e.opd = b1; e.len = 2'd2;
                     e.npc = 16'(opc + 16'd2); e.lat = 3; e.reads = 1; end
         3'd1: begin e.ea = {8'h00, b1}; e.len = 2'd2;
                     e.npc = 16'(opc + 16'd2); e.lat = 3; e.reads = 1; end
         3'd2: begin e.ea = {b1, b2}; e.len = 2'd3;
                     e.npc = 16'(opc + 16'd3); e.lat = 4; e.reads = 2; end
         3'd3: begin e.ea = tgt; e.len = 2'd2;
                     e.npc = tk ? tgt : 16'(opc + 16'd2); e.lat = 3; e.reads = 1; end
         3'd4: begin e.ea = {8'h00, idx}; e.len = 2'd1;
                     e.npc = 16'(opc + 16'd1); e.lat = 1; e.reads = 0; end
         default: begin e.ea = 16'h0000; e.len = 2'd1; e.ill = 1'b1;
                     e.npc = 16'(opc + 16'd1); e.lat = 1; e.reads = 0; end
      endcase
      return e;
   endfunction

   // driver: pushes the expected item, then issues the start
   task automatic run(input string req, input logic [2:0] m, input logic [15:0] opc,
                      input logic [7:0] idx, input logic tk,
                      input logic [7:0] b1, input logic [7:0] b2, input bit hammer);
      @(negedge clk);
      mem_base = opc; mem_b1 = b1; mem_b2 = b2;
      sb.push_back(model(req, m, opc, idx, tk, b1, b2));
      mode_i = m; opc_addr_i = opc; index_i = idx; taken_i = tk;
      start_i = 1'b1;
      t_start = cyc; rd_start = rd_cnt;
      @(negedge clk);
      if (hammer) begin
         mode_i = 3'd4; opc_addr_i = 16'h4444; index_i = 8'h11;
         while (busy_o) @(negedge clk);
      end
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      check(sb.size() == 0, req, "pending results", sb.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "R2", "watchdog expired", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check(!done_o && !busy_o && !mem_rd_o, "R1", "reset outputs",
            {done_o, busy_o, mem_rd_o}, 0);

      run("R3", 3'd0, 16'h1234, 8'h00, 1'b0, 8'hA5, 8'h00, 1'b0);
      run("R4", 3'd1, 16'h8000, 8'h00, 1'b0, 8'h7F, 8'h00, 1'b0);
      run("R5", 3'd2, 16'h2000, 8'h00, 1'b0, 8'hBE, 8'hEF, 1'b0);
      run("R6", 3'd3, 16'h1000, 8'h00, 1'b1, 8'h7F, 8'h00, 1'b0);
      run("R6", 3'd3, 16'h1000, 8'h00, 1'b1, 8'h80, 8'h00, 1'b0);
      run("R7", 3'd3, 16'h1000, 8'h00, 1'b0, 8'h80, 8'h00, 1'b0);
      run("R8", 3'd4, 16'h3000, 8'hC3, 1'b0, 8'h00, 8'h00, 1'b0);
      run("R9", 3'd5, 16'h5000, 8'h22, 1'b0, 8'h00, 8'h00, 1'b0);
      run("R9", 3'd7, 16'hFFFF, 8'h22, 1'b1, 8'h00, 8'h00, 1'b0);
      // R10: wrap of fetch addresses, next PC and branch target
      run("R10", 3'd2, 16'hFFFE, 8'h00, 1'b0, 8'h12, 8'h34, 1'b0);
      run("R10", 3'd3, 16'hFFF0, 8'h00, 1'b1, 8'h7F, 8'h00, 1'b0);
      run("R10", 3'd3, 16'h0000, 8'h00, 1'b1, 8'h80, 8'h00, 1'b0);
      run("R10", 3'd0, 16'hFFFF, 8'h00, 1'b0, 8'h5C, 8'h00, 1'b0);
      // R2: start held high through an extended access, mode switched
      run("R2", 3'd2, 16'h0100, 8'h00, 1'b0, 8'hCA, 8'hFE, 1'b1);

      // R1: reset in the middle of a fetch abandons the operation
      @(negedge clk);
      mode_i = 3'd2; opc_addr_i = 16'h0200; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!busy_o && !done_o && !mem_rd_o, "R1", "mid-flight reset",
            {busy_o, done_o, mem_rd_o}, 0);
      repeat (6) @(negedge clk);
      check(!busy_o, "R1", "stays idle", busy_o, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule